// File: doc/BRIEF.md
# Cascadable FIFO Node with Token-Passing Depth Expansion

This block is one node of a FIFO that can work alone or be joined with identical nodes into a ring to make a deeper buffer. Each node holds its own small memory and its own write and read pointers. In chain mode, ownership of the write side and the read side moves from node to node with a write token and a read token. Only the node that holds the write token stores the shared write strobe. Only the node that holds the read token answers the shared read strobe. When a node's write pointer wraps past its last location, it gives up the write token and sends a one-clock pulse to the next node. The read pointer does the same with a separate pulse. The last node's outputs feed the first node's inputs, so the tokens travel round the ring and the whole chain behaves as a single FIFO of N×DEPTH words.

A strap input picks the mode; holding it high has the same meaning as grounding the expansion input. In single mode no tokens are used. The shared strap/control input then works as an active-low retransmit, which rewinds the read pointer to the first location. The shared output then carries a half-full flag. In chain mode the same input, held low on exactly one node, marks that node as the one loaded first. Strobes and pulses are synchronous to `clk_i`. Read data is registered, and the node drives zero on its data output whenever it has no valid word to present, so the data outputs of a chain can be ORed together.

Top module: `xpand_fifo_node`

## Requirements
- R1: During reset and in the first cycle after it, every node reports empty, not full, output-enable low, data output zero and both pulse outputs low. After that first cycle, in chain mode, only the node with `fl_rt_ni` low holds the write token and the read token.
- R2: In single mode, accepted words come out in write order, and `full_o` goes high after DEPTH words are stored. A write while full is dropped.
- R3: A read while the node is empty is dropped: `rdata_oe_o` stays low and `rdata_o` stays zero in the next cycle.
- R4: In single mode, `xo_wr_hf_o` is high exactly when more than DEPTH/2 words are stored, and `xo_rd_o` stays low.
- R5: In single mode, a cycle with `fl_rt_ni` low sets the read pointer back to location 0 and leaves the write pointer unchanged. Provided no more than DEPTH words were written since reset, reads then replay from the first word written.
- R6: In chain mode, the write that fills location DEPTH-1 of the token holder makes that node raise `xo_wr_hf_o` in the next cycle and give up the write token. The node that sees the pulse takes the token on that clock edge.
- R7: In chain mode, the read of location DEPTH-1 makes the node pulse `xo_rd_o` and hand the read token to the next node in the same way.
- R8: A node without the write token ignores `wr_i`. A node without the read token keeps `rdata_oe_o` low and `rdata_o` zero.
- R9: In chain mode, `fl_rt_ni` has no retransmit effect. Driving it low after reset leaves the output order unchanged.
- R10: With the last node's pulses fed back to the first node, both tokens return to the first node after N×DEPTH operations, and the chain keeps FIFO order across that wrap.
- R11: Each token pulse is high for exactly one clock.
- R12: In chain mode, when the write-token holder is full, further writes are dropped, so the chain never stores more than N×DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| solo_i | input | 1 | Strap: 1 = single mode, 0 = chain mode |
| fl_rt_ni | input | 1 | Chain: first-load mark (low on one node). Single: retransmit, active low |
| xi_wr_i | input | 1 | Write-token pulse from the previous node |
| xi_rd_i | input | 1 | Read-token pulse from the previous node |
| wr_i | input | 1 | Write strobe, one word per clock |
| wdata_i | input | DATA_W | Write data |
| rd_i | input | 1 | Read strobe, one word per clock |
| rdata_o | output | DATA_W | Read data, registered, zero when not enabled |
| rdata_oe_o | output | 1 | High for the cycle after an accepted read |
| full_o | output | 1 | Node holds DEPTH words |
| empty_o | output | 1 | Node holds no words |
| xo_wr_hf_o | output | 1 | Chain: write-token pulse. Single: half-full flag |
| xo_rd_o | output | 1 | Chain: read-token pulse. Single: always low |

## Verification
The bench builds every node with DEPTH=4 and DATA_W=9. Three nodes form a closed ring, and a fourth node runs in single mode. With only four words per node, the bench reaches every pointer wrap, every token hand-off, the return of the tokens to the first node and the full-chain condition within a few dozen operations. In the single-mode node, the half-full threshold lies between the second and third word, and a retransmit replays the whole memory.

// File: rtl/fifo_xp_pkg.sv
package fifo_xp_pkg;
  typedef enum logic {
    MODE_CHAIN = 1'b0,
    MODE_SOLO  = 1'b1
  } xp_mode_e;
endpackage

// File: rtl/xp_ptr_ctl.sv
// One pointer plus its ownership token and hand-off pulse.
module xp_ptr_ctl #(
  parameter int AW = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        chain_i,
  input  logic        first_i,
  input  logic        step_i,
  input  logic        rewind_i,
  input  logic        tok_in_i,
  output logic [AW:0] ptr_o,
  output logic        tok_o,
  output logic        pulse_o
);
  logic [AW:0] ptr_q;
  logic        tok_q, pulse_q, init_q;
  logic        wrap;

  assign wrap = step_i && (ptr_q[AW-1:0] == {AW{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      tok_q   <= 1'b0;
      pulse_q <= 1'b0;
      init_q  <= 1'b1;
    end else begin
      init_q  <= 1'b0;
      pulse_q <= wrap && chain_i;
      if (rewind_i)    ptr_q <= '0;
      else if (step_i) ptr_q <= ptr_q + 1'b1;
      // first cycle after reset loads ownership from the strap
      if (init_q)        tok_q <= first_i && chain_i;
      else if (!chain_i) tok_q <= 1'b0;
      else if (wrap)     tok_q <= tok_in_i;
      else if (tok_in_i) tok_q <= 1'b1;
    end
  end

  assign ptr_o   = ptr_q;
  assign tok_o   = tok_q;
  assign pulse_o = pulse_q;

  AST_PULSE_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R11
  AST_PULSE_FROM_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(tok_o)); // R6
endmodule

// File: rtl/xp_store.sv
// Word storage with a registered, zero-when-idle read port.
module xp_store #(
  parameter int DATA_W = 9,
  parameter int AW     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              oe_o
);
  localparam int WORDS = 1 << AW;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] rdata_q;
  logic              oe_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= re_i;
      if (re_i) rdata_q <= mem_q[raddr_i];
    end
  end

  assign oe_o    = oe_q;
  assign rdata_o = oe_q ? rdata_q : '0;
endmodule

// File: rtl/xpand_fifo_node.sv
module xpand_fifo_node
  import fifo_xp_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              solo_i,
  input  logic              fl_rt_ni,
  input  logic              xi_wr_i,
  input  logic              xi_rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              xo_wr_hf_o,
  output logic              xo_rd_o
);
  localparam int          AW    = $clog2(DEPTH);
  localparam logic [AW:0] FILLC = DEPTH;
  localparam logic [AW:0] HALFC = DEPTH / 2;

  xp_mode_e    mode;
  logic        chain, rewind;
  logic [AW:0] wptr, rptr, fill;
  logic        wtok, rtok, wpulse, rpulse;
  logic        full, empty, half;
  logic        wr_ok, rd_ok;

  assign mode   = solo_i ? MODE_SOLO : MODE_CHAIN;
  assign chain  = (mode == MODE_CHAIN);
  assign rewind = !chain && !fl_rt_ni;

  assign fill  = wptr - rptr;
  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign half  = fill > HALFC;

  assign wr_ok = wr_i && (!chain || wtok) && !full;
  assign rd_ok = rd_i && (!chain || rtok) && !empty && !rewind;

  xp_ptr_ctl #(.AW(AW)) u_wr_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .chain_i  (chain),
    .first_i  (!fl_rt_ni),
    .step_i   (wr_ok),
    .rewind_i (1'b0),
    .tok_in_i (xi_wr_i),
    .ptr_o    (wptr),
    .tok_o    (wtok),
    .pulse_o  (wpulse)
  );

  xp_ptr_ctl #(.AW(AW)) u_rd_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .chain_i  (chain),
    .first_i  (!fl_rt_ni),
    .step_i   (rd_ok),
    .rewind_i (rewind),
    .tok_in_i (xi_rd_i),
    .ptr_o    (rptr),
    .tok_o    (rtok),
    .pulse_o  (rpulse)
  );

  xp_store #(.DATA_W(DATA_W), .AW(AW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ok),
    .waddr_i (wptr[AW-1:0]),
    .wdata_i (wdata_i),
    .re_i    (rd_ok),
    .raddr_i (rptr[AW-1:0]),
    .rdata_o (rdata_o),
    .oe_o    (rdata_oe_o)
  );

  assign full_o     = full;
  assign empty_o    = empty;
  assign xo_wr_hf_o = chain ? wpulse : half;
  assign xo_rd_o    = chain ? rpulse : 1'b0;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= FILLC); // R12
  AST_WR_NEEDS_TOKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain && !wtok) |=> $stable(wptr)); // R8
  AST_OE_NEEDS_TOKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain && rdata_oe_o) |-> $past(rtok)); // R8
  AST_EMPTY_NO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |=> !rdata_oe_o); // R3
  AST_RT_IGNORED_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain && !rd_ok) |=> $stable(rptr)); // R9
  AST_SOLO_NO_RD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo_i |-> !xo_rd_o); // R4
endmodule

// File: tb/tb_xpand_fifo_node.sv
`timescale 1ns/1ps
module tb_xpand_fifo_node;
  localparam int W = 9;
  localparam int D = 4;
  localparam int N = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // chain stimulus
  logic         c_wr = 0, c_rd = 0;
  logic [W-1:0] c_wd = '0;
  logic         fl1_n = 1'b1;
  logic [N-1:0] xw, xr, c_oe, c_full, c_empty;
  logic [W-1:0] c_rdata [N];
  logic [N-1:0] fl_n;
  assign fl_n = {1'b1, fl1_n, 1'b0};

  for (genvar i = 0; i < N; i++) begin : g_ring
    xpand_fifo_node #(.DATA_W(W), .DEPTH(D)) dut (
      .clk_i(clk_i), .rst_ni(rst_ni), .solo_i(1'b0), .fl_rt_ni(fl_n[i]),
      .xi_wr_i(xw[(i+N-1)%N]), .xi_rd_i(xr[(i+N-1)%N]),
      .wr_i(c_wr), .wdata_i(c_wd), .rd_i(c_rd),
      .rdata_o(c_rdata[i]), .rdata_oe_o(c_oe[i]),
      .full_o(c_full[i]), .empty_o(c_empty[i]),
      .xo_wr_hf_o(xw[i]), .xo_rd_o(xr[i]));
  end

  // single-mode node
  logic         s_wr = 0, s_rd = 0, s_rt_n = 1;
  logic [W-1:0] s_wd = '0, s_rdata;
  logic         s_oe, s_full, s_empty, s_hf, s_xr;
  xpand_fifo_node #(.DATA_W(W), .DEPTH(D)) u_solo (
    .clk_i(clk_i), .rst_ni(rst_ni), .solo_i(1'b1), .fl_rt_ni(s_rt_n),
    .xi_wr_i(1'b0), .xi_rd_i(1'b0),
    .wr_i(s_wr), .wdata_i(s_wd), .rd_i(s_rd),
    .rdata_o(s_rdata), .rdata_oe_o(s_oe),
    .full_o(s_full), .empty_o(s_empty),
    .xo_wr_hf_o(s_hf), .xo_rd_o(s_xr));

  logic [W-1:0] q_ch [$];
  logic [W-1:0] q_so [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: scoreboard pops plus pulse bookkeeping
  int wp_cnt [N];
  int rp_cnt [N];
  int wide_pulse = 0;
  logic [N-1:0] xw_prev = '0, xr_prev = '0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic [W-1:0] orv;
      orv = '0;
      for (int i = 0; i < N; i++) begin
        orv |= c_rdata[i];
        if (xw[i]) wp_cnt[i]++;
        if (xr[i]) rp_cnt[i]++;
      end
      if (((xw & xw_prev) | (xr & xr_prev)) != '0) wide_pulse++;
      xw_prev = xw; xr_prev = xr;
      if ($countones(c_oe) > 1) chk(0, "R8 oe count", $countones(c_oe), 1);
      if (c_oe != '0) begin
        if (q_ch.size() == 0) chk(0, "R3/R12 chain unexpected data", orv, -1);
        else begin
          logic [W-1:0] e;
          e = q_ch.pop_front();
          chk(orv == e, "R10 chain order", orv, e);
        end
      end
      if (s_oe) begin
        if (q_so.size() == 0) chk(0, "R3 solo unexpected data", s_rdata, -1);
        else begin
          logic [W-1:0] e;
          e = q_so.pop_front();
          chk(s_rdata == e, "R2/R5 solo order", s_rdata, e);
        end
      end
    end
  end

  task automatic cwrite(input logic [W-1:0] d, input bit ok);
    @(negedge clk_i); c_wr = 1; c_wd = d;
    if (ok) q_ch.push_back(d);
    @(negedge clk_i); c_wr = 0;
    @(negedge clk_i);
  endtask
  task automatic cread();
    @(negedge clk_i); c_rd = 1;
    @(negedge clk_i); c_rd = 0;
    @(negedge clk_i);
  endtask
  task automatic swrite(input logic [W-1:0] d, input bit ok);
    @(negedge clk_i); s_wr = 1; s_wd = d;
    if (ok) q_so.push_back(d);
    @(negedge clk_i); s_wr = 0;
  endtask
  task automatic sread();
    @(negedge clk_i); s_rd = 1;
    @(negedge clk_i); s_rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(c_empty == '1 && c_full == '0, "R1 empty/full", {c_full, c_empty}, 7);
    chk(c_oe == '0 && s_oe == 0 && s_rdata == '0, "R1 oe/data", {c_oe, s_oe}, 0);
    chk(xw == '0 && xr == '0, "R1 pulses", {xw, xr}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // chain fill
    for (int k = 0; k < D; k++) cwrite(9'h100 + k, 1);
    chk(c_full[0] == 1, "R1 first node took writes", c_full[0], 1);
    chk(c_empty[1] == 1 && c_empty[2] == 1, "R8 non-owner ignored write", {c_empty[2], c_empty[1]}, 3);
    chk(wp_cnt[0] == 1, "R6 write pulse", wp_cnt[0], 1);
    cwrite(9'h104, 1);
    chk(c_empty[1] == 0, "R6 next node took token", c_empty[1], 0);
    for (int k = 5; k < N*D; k++) cwrite(9'h100 + k, 1);
    chk(wp_cnt[2] == 1 && wp_cnt[1] == 1 && wp_cnt[0] == 1, "R10 write ring", wp_cnt[2], 1);
    chk(c_full == '1, "R12 chain full", c_full, 7);
    cwrite(9'h1FF, 0);  // dropped: R12
    chk(c_full == '1 && wp_cnt[0] == 1, "R12 overflow dropped", wp_cnt[0], 1);

    // chain drain
    for (int k = 0; k < D; k++) cread();
    chk(rp_cnt[0] == 1, "R7 read pulse", rp_cnt[0], 1);
    cread();
    @(negedge clk_i); fl1_n = 1'b0;  // R9: no retransmit in chain mode
    @(negedge clk_i); fl1_n = 1'b1;
    for (int k = 5; k < N*D; k++) cread();
    chk(q_ch.size() == 0, "R9 all drained in order", q_ch.size(), 0);
    chk(rp_cnt[2] == 1, "R10 read ring", rp_cnt[2], 1);
    cread();  // empty chain: R3
    chk(c_oe == '0 && q_ch.size() == 0, "R3 chain empty read", c_oe, 0);
    cwrite(9'h0AA, 1);
    cwrite(9'h0BB, 1);
    chk(c_empty[0] == 0 && c_empty[1] == 1, "R10 token back at first", c_empty[0], 0);
    cread(); cread();
    chk(q_ch.size() == 0, "R10 wrap data", q_ch.size(), 0);
    chk(wide_pulse == 0, "R11 pulse width", wide_pulse, 0);

    // single mode
    swrite(9'd100, 1); swrite(9'd101, 1);
    @(negedge clk_i);
    chk(s_hf == 0, "R4 half at 2", s_hf, 0);
    swrite(9'd102, 1);
    @(negedge clk_i);
    chk(s_hf == 1, "R4 half at 3", s_hf, 1);
    swrite(9'd103, 1);
    @(negedge clk_i);
    chk(s_full == 1, "R2 full", s_full, 1);
    swrite(9'd199, 0);
    sread(); sread();
    @(negedge clk_i);
    chk(s_hf == 0 && s_full == 0, "R4 half after reads", s_hf, 0);
    @(negedge clk_i); s_rt_n = 0;
    q_so.delete();
    for (int k = 0; k < D; k++) q_so.push_back(W'(100 + k));
    @(negedge clk_i); s_rt_n = 1;
    chk(s_full == 1, "R5 rewind restores fill", s_full, 1);
    for (int k = 0; k < D; k++) sread();
    @(negedge clk_i);
    chk(q_so.size() == 0 && s_empty == 1, "R5 replay complete", q_so.size(), 0);
    sread();
    @(negedge clk_i);
    chk(s_oe == 0 && s_rdata == '0, "R3 solo empty read", s_rdata, 0);
    chk(s_xr == 0, "R4 no read pulse in single mode", s_xr, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule